// File: doc/BRIEF.md
# Loopback Receive Status Checker

This block is the receive half of a network controller's self-test path. A frame looped back from the controller's own transmitter arrives as a serial bit stream with a valid flag. The block discards the preamble up to and including the two-bit sync pair. It then assembles the remaining bits into bytes for the receive FIFO. Along the way it can run a CRC-32 residue check, and it compares the leading destination bytes against the programmed station address.

When the valid flag drops, the block latches a receive status word, a transmit status word and two interrupt flags in one clock. These follow the rules that apply to a looped-back frame:

- The receive-OK bit does not depend on the address.
- A CRC error is reported only for an address-matching frame.
- The packet-received interrupt never rises, because no status is written back to memory.
- With the internal path selected, the carrier-lost and heartbeat-missing bits are forced on, because carrier sense and collision are not visible there.

Diagnostic software compares these words with the results it expects for each loopback configuration.

Top module: `lbk_rx_status_chk`

## Requirements
- R1: While `ser_valid` is high, the bits up to and including the first two consecutive 1 bits of a frame are dropped. Every later bit is gathered into bytes, least significant bit first. Each completed byte appears on `byte_data`, with `byte_valid` high for one cycle, in the cycle after its eighth bit was sampled.
- R2: With `crc_inhibit` at 0, a frame whose CRC-32 register does not reach the residue 0xC704DD7B counts as CRC-bad. The register is preset to all ones and shifts MSB-first over every bit after the sync. A frame carrying a correct Ethernet FCS counts as CRC-good.
- R3: With `crc_inhibit` at 1, no frame counts as CRC-bad, whatever its trailing bytes hold.
- R4: The CRC-error bit `rx_status[1]` is set only when the frame is CRC-bad and the address also matched.
- R5: The receive-OK bit `rx_status[0]` equals "not CRC-bad", whether or not the address matched.
- R6: The address-match bit `rx_status[2]` is set when the frame has at least 6 bytes and received byte k (k = 0..5) equals `station_addr[8k+7:8k]`. A frame with fewer than 6 bytes never matches.
- R7: At the end of each frame `irq_flags[0]` (transmit done) is set. `irq_flags[1]` (packet received) stays 0 at all times.
- R8: At the end of a frame, `tx_status[0]` (carrier lost) and `tx_status[1]` (heartbeat missing) both equal `int_loop`.
- R9: The status outputs update together in the cycle after the first clock at which `ser_valid` is low following a sync. They hold until the first clock with `ser_valid` high after that. On that clock they clear to zero, and the cleared value is visible one cycle later.
- R10: `rx_status[3]` (dribble) is set when the bits after the sync are not a multiple of 8. The trailing partial byte is never presented on `byte_data`.
- R11: After reset, `byte_valid`, `rx_status`, `tx_status` and `irq_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial receive bit |
| ser_valid | input | 1 | High for each bit of a frame; low between frames |
| crc_inhibit | input | 1 | 1 disables the CRC check |
| int_loop | input | 1 | 1 when the internal loopback path is selected |
| station_addr | input | 48 | Station address; byte k is bits 8k+7:8k |
| byte_data | output | 8 | Received byte for the FIFO |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| rx_status | output | 4 | {dribble, address match, CRC error, receive OK} |
| tx_status | output | 2 | {heartbeat missing, carrier lost} |
| irq_flags | output | 2 | {packet received, transmit done} |

## Verification
The assertions rely on a few properties of the inputs:

- `ser_valid` stays high without gaps for the whole of a frame.
- `crc_inhibit`, `int_loop` and `station_addr` are stable in the cycle that ends a frame.
- Every preamble alternates 1,0 so that the first 1,1 pair is the true sync.

The stimulus keeps within these limits. It sends 62 alternating preamble bits before the sync, holds the mode inputs constant across each frame, and leaves an idle gap of several cycles between frames. It uses trailing partial bytes only with the CRC check inhibited.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int unsigned CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_MAGIC = 32'hC704DD7B;

    localparam int unsigned RX_OK    = 0;
    localparam int unsigned RX_CRC   = 1;
    localparam int unsigned RX_MATCH = 2;
    localparam int unsigned RX_DRIB  = 3;
    localparam int unsigned RX_W     = 4;

    localparam int unsigned TX_CARRIER = 0;
    localparam int unsigned TX_HBEAT   = 1;
    localparam int unsigned TX_W       = 2;

    localparam int unsigned IRQ_TXDONE = 0;
    localparam int unsigned IRQ_RXPKT  = 1;
    localparam int unsigned IRQ_W      = 2;

    typedef enum logic {ST_HUNT, ST_DATA} lbk_state_e;
endpackage

// File: rtl/lbk_sync_strip.sv
module lbk_sync_strip
    import lbk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser_bit,
    input  logic ser_valid,
    output logic data_bit,
    output logic data_vld,
    output logic frame_start,
    output logic frame_end
);
    typedef struct packed {
        lbk_state_e state;
        logic       prev_one;
        logic       vld;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = ser_valid;
        if (!ser_valid) begin
            s_d.state    = ST_HUNT;
            s_d.prev_one = 1'b0;
        end else if (s_q.state == ST_HUNT) begin
            if (ser_bit && s_q.prev_one) begin
                s_d.state = ST_DATA;
            end
            s_d.prev_one = ser_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{state: ST_HUNT, prev_one: 1'b0, vld: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign data_bit    = ser_bit;
    assign data_vld    = ser_valid && (s_q.state == ST_DATA);
    assign frame_start = ser_valid && !s_q.vld;
    assign frame_end   = !ser_valid && (s_q.state == ST_DATA);

    // Entry into data phase only follows a sampled 1 within a frame
    assert_sync_pair_R1: assert property (@(posedge clk) disable iff (rst)
        (s_q.state == ST_DATA && $past(s_q.state) == ST_HUNT)
            |-> $past(ser_bit && ser_valid));
endmodule

// File: rtl/lbk_crc_chk.sv
module lbk_crc_chk
    import lbk_pkg::*;
#(
    parameter int unsigned      W     = CRC_W,
    parameter logic [W-1:0]     POLY  = CRC_POLY,
    parameter logic [W-1:0]     INIT  = CRC_INIT,
    parameter logic [W-1:0]     MAGIC = CRC_MAGIC
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_bit,
    input  logic in_vld,
    output logic residue_ok
);
    typedef struct packed {
        logic [W-1:0] reg_v;
    } crc_t;

    crc_t c_d, c_q;
    logic fb;

    always_comb begin
        c_d = c_q;
        fb  = c_q.reg_v[W-1] ^ in_bit;
        if (start) begin
            c_d.reg_v = INIT;
        end else if (in_vld) begin
            c_d.reg_v = {c_q.reg_v[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '{reg_v: INIT};
        end else begin
            c_q <= c_d;
        end
    end

    assign residue_ok = (c_q.reg_v == MAGIC);

    // Register is idle outside of frames: no shift without valid data
    assert_crc_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!start && !in_vld) |=> $stable(c_q.reg_v));
endmodule

// File: rtl/lbk_byte_match.sv
module lbk_byte_match #(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned MATCH_BYTES = 6,
    localparam int unsigned ADDR_W     = BYTE_W * MATCH_BYTES,
    localparam int unsigned BCNT_W     = $clog2(BYTE_W),
    localparam int unsigned IDX_W      = $clog2(MATCH_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_bit,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] station_addr,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_strobe,
    output logic              addr_match,
    output logic              partial
);
    localparam int unsigned SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BCNT_W-1:0] bcnt;
        logic [IDX_W-1:0]  idx;
        logic              match;
        logic [BYTE_W-1:0] out_byte;
        logic              strobe;
    } bm_t;

    bm_t b_d, b_q;
    logic [BYTE_W-1:0] addr_b [SLOTS];
    logic [BYTE_W-1:0] nb;

    for (genvar k = 0; k < SLOTS; k++) begin : g_addr
        if (k < MATCH_BYTES) begin : g_real
            assign addr_b[k] = station_addr[k*BYTE_W +: BYTE_W];
        end else begin : g_pad
            assign addr_b[k] = '0;
        end
    end

    always_comb begin
        b_d        = b_q;
        b_d.strobe = 1'b0;
        nb         = {in_bit, b_q.sh[BYTE_W-1:1]};
        if (start) begin
            b_d.bcnt  = '0;
            b_d.idx   = '0;
            b_d.match = 1'b1;
        end else if (in_vld) begin
            b_d.sh = nb;
            if (b_q.bcnt == BCNT_W'(BYTE_W - 1)) begin
                b_d.bcnt     = '0;
                b_d.out_byte = nb;
                b_d.strobe   = 1'b1;
                if (b_q.idx < IDX_W'(MATCH_BYTES)) begin
                    b_d.match = b_q.match && (nb == addr_b[b_q.idx]);
                    b_d.idx   = b_q.idx + 1'b1;
                end
            end else begin
                b_d.bcnt = b_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign byte_data   = b_q.out_byte;
    assign byte_strobe = b_q.strobe;
    assign addr_match  = b_q.match && (b_q.idx == IDX_W'(MATCH_BYTES));
    assign partial     = (b_q.bcnt != '0);

    assert_strobe_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        byte_strobe |=> !byte_strobe);

    assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
        b_q.idx <= IDX_W'(MATCH_BYTES));
endmodule

// File: rtl/lbk_rx_status_chk.sv
module lbk_rx_status_chk
    import lbk_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ADDR_BYTES = 6,
    localparam int unsigned ADDR_W    = BYTE_W * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    input  logic              ser_valid,
    input  logic              crc_inhibit,
    input  logic              int_loop,
    input  logic [ADDR_W-1:0] station_addr,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic [RX_W-1:0]   rx_status,
    output logic [TX_W-1:0]   tx_status,
    output logic [IRQ_W-1:0]  irq_flags
);
    typedef struct packed {
        logic [RX_W-1:0]  rx;
        logic [TX_W-1:0]  tx;
        logic [IRQ_W-1:0] irq;
    } st_t;

    st_t  st_d, st_q;
    logic d_bit, d_vld, f_start, f_end;
    logic res_ok, a_match, part;
    logic crc_bad;

    lbk_sync_strip u_sync (
        .clk        (clk),
        .rst        (rst),
        .ser_bit    (ser_bit),
        .ser_valid  (ser_valid),
        .data_bit   (d_bit),
        .data_vld   (d_vld),
        .frame_start(f_start),
        .frame_end  (f_end)
    );

    lbk_crc_chk u_crc (
        .clk       (clk),
        .rst       (rst),
        .start     (f_start),
        .in_bit    (d_bit),
        .in_vld    (d_vld),
        .residue_ok(res_ok)
    );

    lbk_byte_match #(
        .BYTE_W     (BYTE_W),
        .MATCH_BYTES(ADDR_BYTES)
    ) u_match (
        .clk         (clk),
        .rst         (rst),
        .start       (f_start),
        .in_bit      (d_bit),
        .in_vld      (d_vld),
        .station_addr(station_addr),
        .byte_data   (byte_data),
        .byte_strobe (byte_valid),
        .addr_match  (a_match),
        .partial     (part)
    );

    always_comb begin
        st_d    = st_q;
        crc_bad = !crc_inhibit && !res_ok;
        if (f_start) begin
            st_d = '0;
        end else if (f_end) begin
            st_d.rx[RX_OK]         = !crc_bad;
            st_d.rx[RX_CRC]        = crc_bad && a_match;
            st_d.rx[RX_MATCH]      = a_match;
            st_d.rx[RX_DRIB]       = part;
            st_d.tx[TX_CARRIER]    = int_loop;
            st_d.tx[TX_HBEAT]      = int_loop;
            st_d.irq[IRQ_TXDONE]   = 1'b1;
            st_d.irq[IRQ_RXPKT]    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_status = st_q.rx;
    assign tx_status = st_q.tx;
    assign irq_flags = st_q.irq;

    assert_crc_needs_match_R4: assert property (@(posedge clk) disable iff (rst)
        rx_status[RX_CRC] |-> rx_status[RX_MATCH]);

    assert_inhibit_no_crc_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_status[RX_CRC]) |-> $past(!crc_inhibit));

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!f_start && !f_end) |=> ($stable(rx_status) && $stable(tx_status) && $stable(irq_flags)));

    assert_tx_loop_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_status[TX_CARRIER]) |-> $past(int_loop));

    assert_byte_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $past(ser_valid));
endmodule

// File: tb/lbk_rx_status_chk_test.sv
`timescale 1ns/1ps
module lbk_rx_status_chk_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_bit = 1'b0;
    logic        ser_valid = 1'b0;
    logic        crc_inhibit = 1'b0;
    logic        int_loop = 1'b0;
    logic [47:0] station_addr = 48'h5E_4D_3C_2B_1A_02;
    logic [7:0]  byte_data;
    logic        byte_valid;
    logic [3:0]  rx_status;
    logic [1:0]  tx_status;
    logic [1:0]  irq_flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] fr[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    lbk_rx_status_chk uut (
        .clk         (clk),
        .rst         (rst),
        .ser_bit     (ser_bit),
        .ser_valid   (ser_valid),
        .crc_inhibit (crc_inhibit),
        .int_loop    (int_loop),
        .station_addr(station_addr),
        .byte_data   (byte_data),
        .byte_valid  (byte_valid),
        .rx_status   (rx_status),
        .tx_status   (tx_status),
        .irq_flags   (irq_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design presents them (R1, R10)
    always @(negedge clk) begin
        if (!rst && byte_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected byte", {24'h0, byte_data}, 32'hFFFF_FFFF);
            end else begin
                check("R1 byte", {24'h0, byte_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    function automatic logic [31:0] crc32(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[i]) begin
            c = c ^ {24'h0, q[i]};
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    function automatic bit calc_match();
        if (fr.size() < 6) return 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (fr[k] != station_addr[8*k +: 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic build(input logic [47:0] dst, input int n_pay, input bit add_fcs, input bit corrupt);
        logic [31:0] c;
        fr.delete();
        for (int k = 0; k < 6; k++) fr.push_back(dst[8*k +: 8]);
        for (int k = 0; k < n_pay; k++) fr.push_back(8'(k * 37 + 5));
        if (add_fcs) begin
            c = crc32(fr);
            for (int k = 0; k < 4; k++) fr.push_back(c[8*k +: 8]);
        end
        if (corrupt) fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h10;
    endtask

    task automatic drive(input logic b);
        @(negedge clk);
        ser_bit   = b;
        ser_valid = 1'b1;
    endtask

    task automatic send(input bit inh, input bit lp, input int extra, input bit crc_bad);
        logic [3:0] exp_rx;
        bit m;
        crc_inhibit = inh;
        int_loop    = lp;
        m = calc_match();
        exp_rx = {extra != 0, m, crc_bad && m, !crc_bad};
        foreach (fr[i]) exp_q.push_back(fr[i]);
        drive(1'b1);
        drive(1'b0);
        // R9: first valid clock cleared the status
        check("R9 clear rx", {28'h0, rx_status}, 32'h0);
        check("R9 clear irq", {30'h0, irq_flags}, 32'h0);
        for (int i = 2; i < 62; i++) drive(i[0] ? 1'b0 : 1'b1);
        drive(1'b1);
        drive(1'b1);
        foreach (fr[i]) begin
            for (int b = 0; b < 8; b++) drive(fr[i][b]);
        end
        for (int b = 0; b < extra; b++) drive(b[0]);
        @(negedge clk);
        ser_valid = 1'b0;
        @(negedge clk);
        check("R5 R4 R6 R10 rx status", {28'h0, rx_status}, {28'h0, exp_rx});
        check("R8 tx status", {30'h0, tx_status}, {30'h0, {lp, lp}});
        check("R7 irq", {30'h0, irq_flags}, 32'h1);
        check("R1 all bytes seen", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        check("R9 hold rx", {28'h0, rx_status}, {28'h0, exp_rx});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 byte_valid", {31'h0, byte_valid}, 32'h0);
        check("R11 rx", {28'h0, rx_status}, 32'h0);
        check("R11 tx", {30'h0, tx_status}, 32'h0);
        check("R11 irq", {30'h0, irq_flags}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 R5 R6 R8: matching, good FCS, internal loopback
        build(station_addr, 20, 1'b1, 1'b0);
        send(1'b0, 1'b1, 0, 1'b0);
        // R5 R6: last address byte differs, good FCS, external path
        build(station_addr ^ 48'h01_00_00_00_00_00, 12, 1'b1, 1'b0);
        send(1'b0, 1'b0, 0, 1'b0);
        // R2 R4: matching, corrupted FCS
        build(station_addr, 15, 1'b1, 1'b1);
        send(1'b0, 1'b1, 0, 1'b1);
        // R4 R5: non-matching, corrupted FCS, no CRC error bit
        build(48'hFF_FF_FF_FF_FF_FF, 9, 1'b1, 1'b1);
        send(1'b0, 1'b0, 0, 1'b1);
        // R3: inhibit with no valid FCS, matching
        build(station_addr, 11, 1'b0, 1'b0);
        send(1'b1, 1'b1, 0, 1'b0);
        // R6: short frame never matches
        fr.delete();
        for (int k = 0; k < 4; k++) fr.push_back(station_addr[8*k +: 8]);
        send(1'b1, 1'b0, 0, 1'b0);
        // R10: trailing partial byte, 3 extra bits
        build(station_addr, 4, 1'b0, 1'b0);
        send(1'b1, 1'b1, 3, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule